// File: doc/BRIEF.md
# Multi-Mode Programmable Frequency Divider

This block sits between a tuner's local-oscillator inputs and its phase comparator. It counts edges of one of two oscillator inputs and emits a single short pulse each time a programmed number of edges has been seen. Both oscillator inputs reach the block as one-cycle tick strobes in the divider clock domain.

A two-bit path selection decides how the 16-bit divisor field is read. With the band bit set, the high-band input passes a fixed divide-by-2 stage before the counter, and the range bit has no effect. With the band bit clear and the range bit set, the low-band input drives the full-width counter directly. With both bits clear, the low-band input drives a 12-bit counter whose divisor is taken from the upper twelve bits of the field.

Configuration is written from a separate control clock domain. A toggle handshake carries it into the divider domain. A changed divisor or path is taken at the end of the period that is running, while an inhibit request acts at once and stops all output pulses.

Top module: `lo_prog_divider`

## Requirements
- R1: With `cfg_band`=1, `div_pulse` fires once every 2×N ticks of `hb_tick`, where N is `cfg_div`. `lb_tick` and `cfg_range` have no effect in this path.
- R2: With `cfg_band`=0 and `cfg_range`=1, `div_pulse` fires once every N ticks of `lb_tick`, where N is `cfg_div`. `hb_tick` is ignored.
- R3: With `cfg_band`=0 and `cfg_range`=0, N is `cfg_div[15:4]`, and bits 3:0 of the field are ignored.
- R4: A divisor below the path minimum is raised to that minimum: 272 for the two full-width paths and 4 for the 12-bit path.
- R5: With `cfg_inhibit`=1, no pulse is produced on any input. When the block is released, the counter and the divide-by-2 stage restart, so the first pulse comes after exactly one full period.
- R6: After reset the block is inhibited and gives no pulses until a configuration is loaded.
- R7: A configuration that changes the divisor or the path, without inhibit, takes effect at the next period end. The period in progress completes with the old setting.
- R8: Each pulse is one `div_clk` cycle wide. It is high in the cycle that follows the input tick that completes the period.
- R9: A load on `cfg_load` reaches the divider through a toggle handshake. If a second load arrives while a transfer is still in flight, that second value is delivered after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Control domain clock |
| cfg_rst_n | input | 1 | Control domain reset, active low, asynchronous |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration fields |
| cfg_div | input | 16 | Divisor field |
| cfg_band | input | 1 | 1 selects the high-band input with the divide-by-2 stage |
| cfg_range | input | 1 | For the low band: 1 selects the full-width counter, 0 the 12-bit counter |
| cfg_inhibit | input | 1 | 1 stops the divider |
| div_clk | input | 1 | Divider domain clock |
| div_rst_n | input | 1 | Divider domain reset, active low, asynchronous |
| hb_tick | input | 1 | High-band oscillator edge strobe |
| lb_tick | input | 1 | Low-band oscillator edge strobe |
| div_pulse | output | 1 | Divided output pulse |

## Verification
The bench drives the selected input with ticks at random spacing and measures the tick count between pulses. It toggles the unselected input at random throughout, so an interval that drifts shows that the wrong input is being counted. Divisor fields are chosen so that each path reading would give a different interval: a high-band field with the range bit clear, narrow fields with nonzero low bits, and values below each minimum. Reconfiguration in mid-period tells apart a divider that reloads at once from one that waits for the period end, and two loads issued back to back test that the pending value is kept.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

   typedef enum logic [1:0] {
      PATH_NARROW = 2'b00,
      PATH_WIDE   = 2'b01,
      PATH_HIGH   = 2'b10
   } path_e;

   function automatic path_e path_of(input logic band, input logic rng);
      if (band)
         return PATH_HIGH;
      else if (rng)
         return PATH_WIDE;
      else
         return PATH_NARROW;
   endfunction

endpackage

// File: rtl/lpd_bit_sync.sv
module lpd_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain_q <= '0;
      else
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lpd_cfg_xfer.sv
module lpd_cfg_xfer #(
   parameter int DW     = 19,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          src_rst_n,
   input  logic          src_load,
   input  logic [DW-1:0] src_data,
   input  logic          dst_clk,
   input  logic          dst_rst_n,
   output logic          dst_valid,
   output logic [DW-1:0] dst_data
);

   logic          req_q;
   logic          pend_q;
   logic [DW-1:0] shadow_q;
   logic [DW-1:0] xfer_q;
   logic          ack_s;
   logic          busy;

   logic          req_s;
   logic          ack_q;
   logic          req_new;

   assign busy = req_q ^ ack_s;

   // source side: latest request kept in shadow while a transfer is open
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         req_q    <= 1'b0;
         pend_q   <= 1'b0;
         shadow_q <= '0;
         xfer_q   <= '0;
      end else begin
         if (src_load)
            shadow_q <= src_data;
         if (src_load && !busy) begin
            xfer_q <= src_data;
            req_q  <= ~req_q;
            pend_q <= 1'b0;
         end else if (src_load) begin
            pend_q <= 1'b1;
         end else if (pend_q && !busy) begin
            xfer_q <= shadow_q;
            req_q  <= ~req_q;
            pend_q <= 1'b0;
         end
      end
   end

   lpd_bit_sync #(.STAGES(STAGES)) u_req_sync (
      .clk  (dst_clk),
      .rst_n(dst_rst_n),
      .d    (req_q),
      .q    (req_s)
   );

   lpd_bit_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk  (src_clk),
      .rst_n(src_rst_n),
      .d    (ack_q),
      .q    (ack_s)
   );

   assign req_new = req_s ^ ack_q;

   // destination side: capture the held word once per toggle
   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         ack_q     <= 1'b0;
         dst_valid <= 1'b0;
         dst_data  <= '0;
      end else begin
         dst_valid <= req_new;
         if (req_new) begin
            dst_data <= xfer_q;
            ack_q    <= req_s;
         end
      end
   end

   // R9: the word seen by the other domain does not move while a toggle is open
   p_xfer_stable_r9: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      busy |=> $stable(xfer_q));

   // R9: a pending load is never left behind once the link is idle
   p_pend_drain_r9: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (pend_q && !busy && !src_load) |=> (!pend_q && busy));

endmodule

// File: rtl/lpd_prescale.sv
module lpd_prescale #(
   parameter int RATIO = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic tick_in,
   output logic tick_out
);

   generate
      if (RATIO == 1) begin : g_bypass
         logic unused_pre;
         assign unused_pre = clk ^ rst_n ^ clr;
         assign tick_out   = tick_in & en;
      end else begin : g_div
         localparam int CW = $clog2(RATIO);
         localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
         logic [CW-1:0] ph_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ph_q <= '0;
            else if (clr)
               ph_q <= '0;
            else if (en && tick_in)
               ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
         end

         assign tick_out = tick_in & en & (ph_q == LAST);

         // R1: the phase counter stays inside its modulus
         p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ph_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/lpd_count_core.sv
module lpd_count_core
   import lpd_pkg::*;
#(
   parameter int DW         = 16,
   parameter int SHIFT      = 4,
   parameter int WIDE_MIN   = 272,
   parameter int NARROW_MIN = 4,
   parameter int PRESCALE   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_valid,
   input  logic [DW+2:0] cfg_data,
   input  logic        hb_tick,
   input  logic        lb_tick,
   output logic        pulse
);

   localparam logic [DW-1:0] N_WIDE_MIN   = DW'(WIDE_MIN);
   localparam logic [DW-1:0] N_NARROW_MIN = DW'(NARROW_MIN);
   localparam logic [DW-1:0] N_ONE        = DW'(1);

   // incoming word decode
   logic [DW-1:0] cfg_field;
   logic          cfg_band;
   logic          cfg_rng;
   logic          cfg_inh;
   path_e         cfg_path;
   logic [DW-1:0] cfg_n;

   assign {cfg_inh, cfg_band, cfg_rng, cfg_field} = cfg_data;
   assign cfg_path = path_of(cfg_band, cfg_rng);

   always_comb begin
      cfg_n = cfg_field;
      case (cfg_path)
         PATH_NARROW: begin
            cfg_n = {{SHIFT{1'b0}}, cfg_field[DW-1:SHIFT]};
            if (cfg_n < N_NARROW_MIN)
               cfg_n = N_NARROW_MIN;
         end
         default: begin
            if (cfg_field < N_WIDE_MIN)
               cfg_n = N_WIDE_MIN;
         end
      endcase
   end

   // staged and active settings
   logic          pend_q;
   logic [DW-1:0] pend_n;
   logic          pend_band;
   logic          pend_inh;

   logic [DW-1:0] act_n;
   logic          act_band;
   logic          act_inh;

   logic [DW-1:0] cnt_q;
   logic          pulse_q;

   logic          pre_tick;
   logic          sel_tick;
   logic          wrap;
   logic          apply_now;
   logic          apply_wrap;
   logic          apply_any;

   assign apply_now  = pend_q & (pend_inh | act_inh);
   assign sel_tick   = ~act_inh & (act_band ? pre_tick : lb_tick);
   assign wrap       = sel_tick & (cnt_q == N_ONE);
   assign apply_wrap = pend_q & wrap & ~apply_now;
   assign apply_any  = apply_now | apply_wrap;

   lpd_prescale #(.RATIO(PRESCALE)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (apply_now),
      .en      (act_band & ~act_inh),
      .tick_in (hb_tick),
      .tick_out(pre_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_n    <= N_WIDE_MIN;
         pend_band <= 1'b0;
         pend_inh  <= 1'b1;
      end else if (cfg_valid) begin
         pend_q    <= 1'b1;
         pend_n    <= cfg_n;
         pend_band <= cfg_band;
         pend_inh  <= cfg_inh;
      end else if (apply_any) begin
         pend_q    <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_n    <= N_WIDE_MIN;
         act_band <= 1'b0;
         act_inh  <= 1'b1;
         cnt_q    <= N_WIDE_MIN;
         pulse_q  <= 1'b0;
      end else begin
         if (apply_any) begin
            act_n    <= pend_n;
            act_band <= pend_band;
            act_inh  <= pend_inh;
            cnt_q    <= pend_n;
         end else if (wrap) begin
            cnt_q    <= act_n;
         end else if (sel_tick) begin
            cnt_q    <= cnt_q - 1'b1;
         end
         pulse_q <= wrap & ~(apply_now & pend_inh);
      end
   end

   assign pulse = pulse_q;

   // R5: an inhibited divider is silent
   p_inhibit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_inh |-> !pulse_q);

   // R4: the running count never reaches zero nor exceeds the divisor
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_inh |-> (cnt_q != '0 && cnt_q <= act_n));

   // R4: the active divisor is never below the smallest legal value
   p_n_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_n >= N_NARROW_MIN);

   // R8: pulses are a single cycle wide
   p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R8: a pulse always follows a counted tick
   p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(sel_tick));

   // R7: with nothing staged the active divisor holds
   p_no_spurious_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> $stable(act_n));

endmodule

// File: rtl/lo_prog_divider.sv
module lo_prog_divider #(
   parameter int DIV_W        = 16,
   parameter int NARROW_SHIFT = 4,
   parameter int WIDE_MIN     = 272,
   parameter int NARROW_MIN   = 4,
   parameter int PRESCALE     = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             cfg_clk,
   input  logic             cfg_rst_n,
   input  logic             cfg_load,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_band,
   input  logic             cfg_range,
   input  logic             cfg_inhibit,
   input  logic             div_clk,
   input  logic             div_rst_n,
   input  logic             hb_tick,
   input  logic             lb_tick,
   output logic             div_pulse
);

   localparam int XW = DIV_W + 3;

   generate
      if (DIV_W < 8) begin : g_chk_w
         $error("divisor width too small");
      end
      if (NARROW_SHIFT < 1 || NARROW_SHIFT >= DIV_W) begin : g_chk_shift
         $error("narrow shift out of range");
      end
      if (NARROW_MIN < 2 || WIDE_MIN < 2) begin : g_chk_min
         $error("minimum divisor must be at least 2");
      end
      if (WIDE_MIN >= (1 << DIV_W) || NARROW_MIN >= (1 << (DIV_W - NARROW_SHIFT))) begin : g_chk_max
         $error("minimum divisor does not fit the field");
      end
      if (PRESCALE < 1) begin : g_chk_pre
         $error("prescale ratio must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("synchronizer needs two stages or more");
      end
   endgenerate

   logic          x_valid;
   logic [XW-1:0] x_data;

   lpd_cfg_xfer #(.DW(XW), .STAGES(SYNC_STAGES)) u_xfer (
      .src_clk  (cfg_clk),
      .src_rst_n(cfg_rst_n),
      .src_load (cfg_load),
      .src_data ({cfg_inhibit, cfg_band, cfg_range, cfg_div}),
      .dst_clk  (div_clk),
      .dst_rst_n(div_rst_n),
      .dst_valid(x_valid),
      .dst_data (x_data)
   );

   lpd_count_core #(
      .DW        (DIV_W),
      .SHIFT     (NARROW_SHIFT),
      .WIDE_MIN  (WIDE_MIN),
      .NARROW_MIN(NARROW_MIN),
      .PRESCALE  (PRESCALE)
   ) u_core (
      .clk      (div_clk),
      .rst_n    (div_rst_n),
      .cfg_valid(x_valid),
      .cfg_data (x_data),
      .hb_tick  (hb_tick),
      .lb_tick  (lb_tick),
      .pulse    (div_pulse)
   );

endmodule

// File: tb/sim_lo_prog_divider.sv
`timescale 1ns/1ps
module sim_lo_prog_divider;

   logic        cfg_clk = 1'b0;
   logic        div_clk = 1'b0;
   logic        cfg_rst_n = 1'b0;
   logic        div_rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [15:0] cfg_div = '0;
   logic        cfg_band = 1'b0;
   logic        cfg_range = 1'b0;
   logic        cfg_inhibit = 1'b0;
   logic        hb_tick = 1'b0;
   logic        lb_tick = 1'b0;
   logic        div_pulse;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 div_clk = ~div_clk;
   always #5 cfg_clk = ~cfg_clk;

   lo_prog_divider u0 (
      .cfg_clk    (cfg_clk),
      .cfg_rst_n  (cfg_rst_n),
      .cfg_load   (cfg_load),
      .cfg_div    (cfg_div),
      .cfg_band   (cfg_band),
      .cfg_range  (cfg_range),
      .cfg_inhibit(cfg_inhibit),
      .div_clk    (div_clk),
      .div_rst_n  (div_rst_n),
      .hb_tick    (hb_tick),
      .lb_tick    (lb_tick),
      .div_pulse  (div_pulse)
   );

   function automatic int exp_ticks(input logic [15:0] f, input bit band, input bit rng);
      int n;
      if (band || rng) begin
         n = int'(f);
         if (n < 272) n = 272;
      end else begin
         n = int'(f) >> 4;
         if (n < 4) n = 4;
      end
      return band ? 2 * n : n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_cfg(input logic [15:0] f, input bit band, input bit rng, input bit inh);
      @(negedge cfg_clk);
      cfg_div = f; cfg_band = band; cfg_range = rng; cfg_inhibit = inh; cfg_load = 1'b1;
      @(negedge cfg_clk);
      cfg_load = 1'b0;
   endtask

   task automatic load_cfg(input logic [15:0] f, input bit band, input bit rng, input bit inh);
      drive_cfg(f, band, rng, inh);
      repeat (14) @(negedge div_clk);
   endtask

   task automatic restart(input logic [15:0] f, input bit band, input bit rng);
      load_cfg(16'd0, 1'b0, 1'b0, 1'b1);
      load_cfg(f, band, rng, 1'b0);
   endtask

   task automatic one_tick(input bit hb_sel, output bit p);
      @(negedge div_clk);
      if (hb_sel) begin
         hb_tick = 1'b1; lb_tick = 1'($urandom_range(0, 1));
      end else begin
         lb_tick = 1'b1; hb_tick = 1'($urandom_range(0, 1));
      end
      @(negedge div_clk);
      hb_tick = 1'b0; lb_tick = 1'b0;
      p = div_pulse;
   endtask

   task automatic go_ticks(input bit hb_sel, input int first_exp, input int exp,
                           input int npulses, input string req);
      int seen = 0;
      int since = 0;
      int guard = 0;
      bit p;
      while (seen < npulses && guard < 20000) begin
         one_tick(hb_sel, p);
         since++; guard++;
         if (p) begin
            int e = (seen == 0) ? first_exp : exp;
            if (e != 0) check(since == e, req, since, e, "ticks per pulse");
            @(negedge div_clk);
            check(div_pulse == 1'b0, "R8", int'(div_pulse), 0, "pulse width");
            since = 0;
            seen++;
         end
         if ($urandom_range(0, 2) == 0) @(negedge div_clk);
      end
      if (seen < npulses) check(1'b0, req, seen, npulses, "pulses seen");
   endtask

   task automatic quiet(input int n, input string req);
      int cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge div_clk);
         hb_tick = 1'($urandom_range(0, 1)); lb_tick = 1'($urandom_range(0, 1));
         @(negedge div_clk);
         hb_tick = 1'b0; lb_tick = 1'b0;
         if (div_pulse) cnt++;
      end
      check(cnt == 0, req, cnt, 0, "pulses while stopped");
   endtask

   initial begin
      repeat (200000) @(posedge div_clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      bit p;
      void'($urandom(32'h5eed_1234));
      repeat (5) @(negedge div_clk);
      cfg_rst_n = 1'b1; div_rst_n = 1'b1;
      repeat (3) @(negedge div_clk);

      // R6: reset state gives no pulses
      check(div_pulse == 1'b0, "R6", int'(div_pulse), 0, "pulse at reset");
      quiet(400, "R6");

      // R1: high band, 2014 at a 25 kHz step -> 100.7 MHz, 4028 input edges
      load_cfg(16'd2014, 1'b1, 1'b1, 1'b0);
      go_ticks(1'b1, exp_ticks(16'd2014, 1'b1, 1'b1), 4028, 1, "R1");

      // R2: full-width low band, 0x1158 -> 4440 edges
      restart(16'h1158, 1'b0, 1'b1);
      go_ticks(1'b0, 4440, 4440, 1, "R2");

      // R5: inhibit mid-period, then release restarts the count
      restart(16'd300, 1'b0, 1'b1);
      for (int i = 0; i < 50; i++) one_tick(1'b0, p);
      load_cfg(16'd300, 1'b0, 1'b1, 1'b1);
      quiet(600, "R5");
      load_cfg(16'd300, 1'b0, 1'b1, 1'b0);
      go_ticks(1'b0, 300, 300, 2, "R5");

      // R1: range bit ignored on the high band (narrow reading would give 36)
      restart(16'd300, 1'b1, 1'b0);
      go_ticks(1'b1, 600, 600, 2, "R1");

      // R3: narrow path uses bits 15:4 only
      restart(16'h00A7, 1'b0, 1'b0);
      go_ticks(1'b0, 10, 10, 3, "R3");
      restart(16'h0A2F, 1'b0, 1'b0);
      go_ticks(1'b0, 162, 162, 2, "R3");

      // R4: clamps
      restart(16'd5, 1'b0, 1'b1);
      go_ticks(1'b0, 272, 272, 2, "R4");
      restart(16'd0, 1'b1, 1'b1);
      go_ticks(1'b1, 544, 544, 1, "R4");
      restart(16'h0015, 1'b0, 1'b0);
      go_ticks(1'b0, 4, 4, 3, "R4");
      restart(16'h000F, 1'b0, 1'b0);
      go_ticks(1'b0, 4, 4, 3, "R4");

      // R7: new divisor waits for the period end
      restart(16'd300, 1'b0, 1'b1);
      go_ticks(1'b0, 300, 300, 1, "R7");
      load_cfg(16'd280, 1'b0, 1'b1, 1'b0);
      go_ticks(1'b0, 300, 280, 2, "R7");
      // R7: path change waits for the period end too
      load_cfg(16'd280, 1'b1, 1'b1, 1'b0);
      go_ticks(1'b0, 280, 0, 1, "R7");
      go_ticks(1'b1, 560, 560, 2, "R7");

      // R9: back-to-back loads, the second arrives later and applies at a wrap
      load_cfg(16'd0, 1'b0, 1'b0, 1'b1);
      drive_cfg(16'd300, 1'b0, 1'b1, 1'b0);
      drive_cfg(16'd320, 1'b0, 1'b1, 1'b0);
      repeat (30) @(negedge div_clk);
      go_ticks(1'b0, 300, 320, 2, "R9");

      // random configurations across all paths
      for (int k = 0; k < 8; k++) begin
         int sel = $urandom_range(0, 2);
         logic [15:0] f;
         bit b, r;
         if (sel == 0) begin
            b = 1'b1; r = 1'($urandom_range(0, 1)); f = 16'($urandom_range(250, 330));
         end else if (sel == 1) begin
            b = 1'b0; r = 1'b1; f = 16'($urandom_range(250, 360));
         end else begin
            b = 1'b0; r = 1'b0;
            f = 16'(($urandom_range(2, 40) << 4) | $urandom_range(0, 15));
         end
         restart(f, b, r);
         go_ticks(b, exp_ticks(f, b, r), exp_ticks(f, b, r), 2,
                  (sel == 0) ? "R1" : (sel == 1) ? "R2" : "R3");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule